// File: doc/BRIEF.md
# Configurable Delay Timer with Status Flags

This block is a single timing element for sequential control logic. A level input, the rung, drives it. The accumulator counts whole periods of a selectable time base, and the block compares that count against a 16-bit preset. A static mode input chooses one of three behaviours: on-delay (done rises after the rung has been true for the preset time), off-delay (done rises with the rung and falls once the rung has been false for the preset time), and retentive (time adds up over separate true intervals until an explicit clear). An internal prescaler derives the time base from the system clock, whose frequency is the parameter `CLK_HZ`.

The controller is a four-state machine:
- IDLE: nothing timed, accumulator at zero, or the off-delay count has expired.
- TIMING: the accumulator advances once per base period.
- DONE: the preset has been reached, or an off-delay rung is true.
- HOLD: a retentive count has stopped partway through.

The transitions are:
- start: IDLE or HOLD to TIMING.
- expire: TIMING to DONE in on-delay or retentive mode, or TIMING to IDLE in off-delay mode.
- pause: TIMING to HOLD in retentive mode.
- drop: any state to IDLE on a false on-delay rung.
- arm: any state to DONE on a true off-delay rung.
- release: DONE to TIMING when an off-delay rung falls.
- clear: any state to IDLE on the clear input.

All status outputs are registered and change on the clock edge that samples the input causing the change.

Top module: `multimode_timer`

## Requirements
- R1: `base_sel_i` picks the base period: code 0 is CLK_HZ/100 clock cycles, code 1 is CLK_HZ/10, and codes 2 and 3 are CLK_HZ. While timing, the accumulator advances by exactly one per base period.
- R2: `en_o` equals the value of `rung_i` sampled at the most recent clock edge.
- R3: `tt_o` is high only in TIMING, which means the accumulator is advancing or is eligible to advance.
- R4: In on-delay mode (`mode_i` = 0, and also code 3), with the rung held true, the accumulator reaches N after N base periods. `dn_o` rises on the edge where the accumulator equals the preset, `tt_o` falls on that same edge, and the accumulator then stays at the preset.
- R5: In on-delay mode, a false rung clears the accumulator and `dn_o` on the next edge.
- R6: In off-delay mode (`mode_i` = 1), a true rung sets `dn_o` and holds the accumulator at zero, with `tt_o` low.
- R7: In off-delay mode, after the rung falls, `dn_o` and `tt_o` are both high until the accumulator reaches the preset. At that edge both clear, and the accumulator stays at the preset.
- R8: In off-delay mode, a rung that returns true during timing sets the accumulator back to zero and keeps `dn_o` high.
- R9: In retentive mode (`mode_i` = 2), time accumulates only while the rung is true. The accumulator and the prescaler phase are both held while the rung is false, and timing resumes from them.
- R10: In retentive mode, once the accumulator reaches the preset, `dn_o` stays high whatever the rung does, until the clear input is applied.
- R11: `acc_clr_i` high clears the accumulator, `dn_o` and `tt_o` on the next edge in every mode, and it overrides a true rung.
- R12: When timing starts from an accumulator of zero, the prescaler restarts, so the first increment comes exactly one full base period after the start edge.
- R13: In on-delay mode with a preset of zero, a true rung sets `dn_o` on the next edge without entering TIMING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| rung_i | input | 1 | Rung condition |
| acc_clr_i | input | 1 | Clears the accumulator and status bits |
| mode_i | input | 2 | 0 on-delay, 1 off-delay, 2 retentive, 3 on-delay |
| base_sel_i | input | 2 | Time base select (see R1) |
| preset_i | input | 16 | Preset in base periods |
| en_o | output | 1 | Enable status (registered rung) |
| tt_o | output | 1 | Timing-in-progress status |
| dn_o | output | 1 | Done status |
| acc_o | output | 16 | Accumulated base periods |

## Verification
The bench samples the accumulator one cycle before and one cycle on the first increment after a start. A prescaler that keeps a stale phase, or that starts counting one cycle late, would therefore show an early or late step. In retentive mode it pauses partway through a base period and resumes. A design that restarted the prescaler on resume would land its next increment late, and one that counted during the pause would drift the held value. Off-delay timing is interrupted by a returning rung to show that the accumulator restarts and done never drops. A zero preset and a clear applied while the rung is true expose logic that forgets the bypass to DONE or the priority of the clear.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

    typedef enum logic [1:0] {
        MODE_ON_DELAY  = 2'd0,
        MODE_OFF_DELAY = 2'd1,
        MODE_RETAIN    = 2'd2
    } mmt_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TIMING = 2'd1,
        ST_DONE   = 2'd2,
        ST_HOLD   = 2'd3
    } mmt_state_e;

endpackage

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] base_sel_i,
    input  logic       run_i,
    input  logic       clr_i,
    output logic       tick_o
);
    localparam int CW = $clog2(CLK_HZ) + 1;
    localparam logic [CW-1:0] LIM_FINE   = CW'(CLK_HZ / 100 - 1);
    localparam logic [CW-1:0] LIM_MID    = CW'(CLK_HZ / 10 - 1);
    localparam logic [CW-1:0] LIM_COARSE = CW'(CLK_HZ - 1);

    logic [CW-1:0] lim;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        case (base_sel_i)
            2'd0:    lim = LIM_FINE;
            2'd1:    lim = LIM_MID;
            default: lim = LIM_COARSE;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = (cnt_q == lim) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = run_i && (cnt_q == lim);

    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && $stable(base_sel_i)) |=> (cnt_q <= lim));

    // R9
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_i) |=> $stable(cnt_q));

    // R12
    phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/mmt_core.sv
module mmt_core
    import mmt_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rung_i,
    input  logic          clr_i,
    input  logic [1:0]    mode_i,
    input  logic [AW-1:0] preset_i,
    input  logic          tick_i,
    output logic          run_o,
    output logic          pclr_o,
    output logic          en_o,
    output logic          tt_o,
    output logic          dn_o,
    output logic [AW-1:0] acc_o
);
    mmt_mode_e     mode;
    mmt_state_e    st_q;
    mmt_state_e    st_d;
    logic [AW-1:0] acc_q;
    logic [AW-1:0] acc_d;
    logic [AW:0]   acc_inc;
    logic          at_preset;
    logic          reach_next;
    logic          en_q;

    always_comb begin
        case (mode_i)
            2'd1:    mode = MODE_OFF_DELAY;
            2'd2:    mode = MODE_RETAIN;
            default: mode = MODE_ON_DELAY;
        endcase
    end

    assign acc_inc    = {1'b0, acc_q} + {{AW{1'b0}}, 1'b1};
    assign at_preset  = (acc_q >= preset_i);
    assign reach_next = (acc_inc >= {1'b0, preset_i});

    // next-state and accumulator logic
    always_comb begin
        st_d  = st_q;
        acc_d = acc_q;
        if (clr_i) begin
            st_d  = ST_IDLE;
            acc_d = '0;
        end else begin
            unique case (mode)
                MODE_ON_DELAY: begin
                    if (!rung_i) begin
                        st_d  = ST_IDLE;
                        acc_d = '0;
                    end else begin
                        unique case (st_q)
                            ST_TIMING: begin
                                if (tick_i) begin
                                    acc_d = acc_inc[AW-1:0];
                                    st_d  = reach_next ? ST_DONE : ST_TIMING;
                                end
                            end
                            ST_DONE: st_d = ST_DONE;
                            ST_IDLE,
                            ST_HOLD: st_d = at_preset ? ST_DONE : ST_TIMING;
                        endcase
                    end
                end
                MODE_OFF_DELAY: begin
                    if (rung_i) begin
                        st_d  = ST_DONE;
                        acc_d = '0;
                    end else begin
                        unique case (st_q)
                            ST_DONE: st_d = (preset_i == '0) ? ST_IDLE : ST_TIMING;
                            ST_TIMING: begin
                                if (tick_i) begin
                                    acc_d = acc_inc[AW-1:0];
                                    st_d  = reach_next ? ST_IDLE : ST_TIMING;
                                end
                            end
                            ST_IDLE,
                            ST_HOLD: st_d = ST_IDLE;
                        endcase
                    end
                end
                MODE_RETAIN: begin
                    if (rung_i) begin
                        unique case (st_q)
                            ST_DONE: st_d = ST_DONE;
                            ST_TIMING: begin
                                if (tick_i) begin
                                    acc_d = acc_inc[AW-1:0];
                                    st_d  = reach_next ? ST_DONE : ST_TIMING;
                                end
                            end
                            ST_IDLE,
                            ST_HOLD: st_d = at_preset ? ST_DONE : ST_TIMING;
                        endcase
                    end else begin
                        unique case (st_q)
                            ST_DONE: st_d = ST_DONE;
                            ST_IDLE,
                            ST_TIMING,
                            ST_HOLD: st_d = (acc_q == '0) ? ST_IDLE : ST_HOLD;
                        endcase
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            acc_q <= '0;
            en_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            acc_q <= acc_d;
            en_q  <= rung_i;
        end
    end

    // outputs
    always_comb begin
        tt_o   = (st_q == ST_TIMING);
        dn_o   = (st_q == ST_DONE) || ((mode == MODE_OFF_DELAY) && (st_q == ST_TIMING));
        run_o  = (st_q == ST_TIMING) && ((mode == MODE_OFF_DELAY) ? !rung_i : rung_i);
        pclr_o = clr_i || ((st_q != ST_TIMING) && (acc_q == '0));
        en_o   = en_q;
        acc_o  = acc_q;
    end

    // R4
    on_delay_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_ON_DELAY) && $stable(preset_i)) |-> (acc_q <= preset_i));

    // R5
    on_delay_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_ON_DELAY) && !rung_i && !clr_i) |=> ((acc_o == '0) && !dn_o));

    // R7
    off_delay_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_OFF_DELAY) && tt_o) |-> dn_o);

    // R9
    retain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_RETAIN) && !rung_i && !clr_i) |=> $stable(acc_q));

    // R10
    retain_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_RETAIN) && (st_q == ST_DONE) && !clr_i) |=> dn_o);

    // R11
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((acc_o == '0) && !tt_o && !dn_o));

endmodule

// File: rtl/multimode_timer.sv
module multimode_timer #(
    parameter int CLK_HZ = 100_000_000,
    parameter int AW     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rung_i,
    input  logic          acc_clr_i,
    input  logic [1:0]    mode_i,
    input  logic [1:0]    base_sel_i,
    input  logic [AW-1:0] preset_i,
    output logic          en_o,
    output logic          tt_o,
    output logic          dn_o,
    output logic [AW-1:0] acc_o
);
    logic tick;
    logic run;
    logic pclr;

    mmt_prescaler #(.CLK_HZ(CLK_HZ)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_sel_i (base_sel_i),
        .run_i      (run),
        .clr_i      (pclr),
        .tick_o     (tick)
    );

    mmt_core #(.AW(AW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rung_i   (rung_i),
        .clr_i    (acc_clr_i),
        .mode_i   (mode_i),
        .preset_i (preset_i),
        .tick_i   (tick),
        .run_o    (run),
        .pclr_o   (pclr),
        .en_o     (en_o),
        .tt_o     (tt_o),
        .dn_o     (dn_o),
        .acc_o    (acc_o)
    );

endmodule

// File: tb/test_multimode_timer.sv
module test_multimode_timer;
    localparam int CLK_PERIOD = 10;
    localparam int HZ = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rung = 1'b0;
    logic        clr = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [1:0]  bsel = 2'd0;
    logic [15:0] preset = 16'd0;
    logic        en;
    logic        tt;
    logic        dn;
    logic [15:0] acc;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    multimode_timer #(.CLK_HZ(HZ), .AW(16)) i_multimode_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rung_i     (rung),
        .acc_clr_i  (clr),
        .mode_i     (mode),
        .base_sel_i (bsel),
        .preset_i   (preset),
        .en_o       (en),
        .tt_o       (tt),
        .dn_o       (dn),
        .acc_o      (acc)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input int act, input int exp, input string what);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic status(input int e_en, input int e_tt, input int e_dn, input int e_acc,
                          input string tag);
        chk(int'(en), e_en, {tag, " en"});
        chk(int'(tt), e_tt, {tag, " tt"});
        chk(int'(dn), e_dn, {tag, " dn"});
        chk(int'(acc), e_acc, {tag, " acc"});
    endtask

    task automatic settle();
        rung = 1'b0;
        clr  = 1'b1;
        step(1);
        clr  = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        status(0, 0, 0, 0, "reset R11");
    endtask

    task automatic t_on_delay();
        settle();
        mode = 2'd0; bsel = 2'd0; preset = 16'd5;
        rung = 1'b1;
        step(1);
        status(1, 1, 0, 0, "R2 R3 on start");
        step(9);
        chk(int'(acc), 0, "R12 before first period");
        step(1);
        chk(int'(acc), 1, "R12 first increment");
        step(39);
        status(1, 1, 0, 4, "R4 one before preset");
        step(1);
        status(1, 0, 1, 5, "R4 reach preset");
        step(30);
        status(1, 0, 1, 5, "R4 saturate");
        rung = 1'b0;
        step(1);
        status(0, 0, 0, 0, "R5 drop");
    endtask

    task automatic t_on_restart();
        settle();
        mode = 2'd0; bsel = 2'd0; preset = 16'd9;
        rung = 1'b1;
        step(26);
        chk(int'(acc), 2, "R4 partial");
        rung = 1'b0;
        step(1);
        status(0, 0, 0, 0, "R5 partial drop");
        rung = 1'b1;
        step(10);
        chk(int'(acc), 0, "R12 restart no early step");
        step(1);
        chk(int'(acc), 1, "R12 restart full period");
    endtask

    task automatic t_bases();
        settle();
        mode = 2'd0; bsel = 2'd1; preset = 16'd3;
        rung = 1'b1;
        step(300);
        status(1, 1, 0, 2, "R1 base1 before");
        step(1);
        status(1, 0, 1, 3, "R1 base1 done");
        settle();
        bsel = 2'd2; preset = 16'd1;
        rung = 1'b1;
        step(1000);
        chk(int'(acc), 0, "R1 base2 before");
        step(1);
        chk(int'(dn), 1, "R1 base2 done");
        settle();
        bsel = 2'd3;
        rung = 1'b1;
        step(1000);
        chk(int'(dn), 0, "R1 base3 before");
        step(1);
        chk(int'(dn), 1, "R1 base3 done");
    endtask

    task automatic t_zero_preset();
        settle();
        mode = 2'd0; bsel = 2'd0; preset = 16'd0;
        rung = 1'b1;
        step(1);
        status(1, 0, 1, 0, "R13 zero preset");
    endtask

    task automatic t_off_delay();
        settle();
        mode = 2'd1; bsel = 2'd0; preset = 16'd3;
        rung = 1'b1;
        step(1);
        status(1, 0, 1, 0, "R6 arm");
        step(20);
        status(1, 0, 1, 0, "R6 held at zero");
        rung = 1'b0;
        step(1);
        status(0, 1, 1, 0, "R7 release");
        step(20);
        status(0, 1, 1, 2, "R7 mid");
        rung = 1'b1;
        step(1);
        status(1, 0, 1, 0, "R8 re-arm");
        rung = 1'b0;
        step(30);
        status(0, 1, 1, 2, "R7 retime");
        step(1);
        status(0, 0, 0, 3, "R7 expire");
        step(20);
        status(0, 0, 0, 3, "R7 hold after expire");
    endtask

    task automatic t_retain();
        settle();
        mode = 2'd2; bsel = 2'd0; preset = 16'd4;
        rung = 1'b1;
        step(26);
        status(1, 1, 0, 2, "R9 first interval");
        rung = 1'b0;
        step(1);
        status(0, 0, 0, 2, "R9 pause");
        step(30);
        chk(int'(acc), 2, "R9 held while false");
        rung = 1'b1;
        step(1);
        status(1, 1, 0, 2, "R9 resume");
        step(4);
        chk(int'(acc), 2, "R9 phase kept before");
        step(1);
        chk(int'(acc), 3, "R9 phase kept step");
        step(9);
        chk(int'(acc), 3, "R10 before done");
        step(1);
        status(1, 0, 1, 4, "R10 done");
        rung = 1'b0;
        step(5);
        status(0, 0, 1, 4, "R10 latched");
        clr = 1'b1;
        step(1);
        status(0, 0, 0, 0, "R11 clear");
        clr = 1'b0;
        rung = 1'b1;
        step(16);
        chk(int'(acc), 1, "R9 restart");
        clr = 1'b1;
        step(1);
        status(1, 0, 0, 0, "R11 over rung");
        step(20);
        status(1, 0, 0, 0, "R11 held");
        clr = 1'b0;
        rung = 1'b0;
        step(1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_on_delay();
        t_on_restart();
        t_bases();
        t_zero_preset();
        t_off_delay();
        t_retain();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule